// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block lets synchronous logic use an external asynchronous static RAM with a data bus split into byte lanes. A host hands it one request at a time over a valid/ready port: an address, a read/write flag, write data and one enable bit per byte lane. The sequencer then drives the active-low chip-select, output-enable, write-strobe and per-lane byte strobes, and drives or releases the bidirectional data pins. It answers with a one-cycle read-data pulse or a one-cycle write-complete pulse.

Every minimum interval the memory needs is a nanosecond parameter. Each one is turned into a whole number of clock cycles at elaboration, using a clock-period parameter. One netlist can therefore serve memories of different speed grades, and different clock rates, by changing parameters only. A write ends on a single edge: the write strobe rises first. Chip-select and the byte strobes stay low for at least one more cycle, so data setup and hold are always measured from that one edge. After every read, the data pins stay undriven until the memory's output turn-off window has passed.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and just after it, the chip-select, output-enable and write strobes are high, all byte strobes are high, `req_ready` is high and the data pins are not driven.
- R2: Each interval is max(1, ceil(t_ns*1000 / CLK_PS)) cycles.
- R3: A read holds chip-select, output-enable and every byte strobe low together, with the write strobe high. This lasts exactly max(read-cycle, address-access, select-access, output-enable-access, byte-access) cycles.
- R4: Read data is sampled on the last edge of the strobe window. `rsp_rdata` with `rsp_rvalid` is presented for exactly one cycle right after that edge.
- R5: A write holds chip-select and the write strobe low, with output-enable high throughout. Byte strobe bit n (`sram_be_n[n]`, bit 0 for data 7:0, bit 1 for data 15:8) is low exactly when `req_be[n]` was 1.
- R6: The write strobe stays low for exactly max(pulse-width, data-setup, address-to-end, select-to-end, byte-to-end) cycles. It then rises while chip-select is still low. Chip-select stays low for max(that count + 1, write-cycle) cycles in total.
- R7: Write data is driven on the pins and held unchanged for the whole time the write strobe is low, and is still driven when it rises.
- R8: A byte lane whose enable bit is 0 keeps its stored contents. A write with both enable bits 0 changes no data.
- R9: The data pins are never driven while output-enable is low. After output-enable rises, they are not driven for at least the output-turn-off interval.
- R10: `req_ready` is high only while no sequence is running, and requests are accepted only then. Each write ends with a one-cycle `rsp_wdone` pulse.
- R11: `sram_addr` does not change while chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Per-lane write enable, bit 0 = data 7:0 |
| rsp_rvalid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| rsp_wdone | output | 1 | One-cycle write complete |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_be_n | output | DATA_W/8 | Byte strobes, active low, bit 0 = data 7:0 |
| sram_dq | inout | DATA_W | Bidirectional data pins |

## Verification
The bench writes with all lanes enabled, the low lane only, the high lane only and neither lane, then reads each word back. Merged words such as AA34 and 56CC show that lane masking works and that the lanes are not swapped. The all-zero write proves that no stray write happens. Strobe widths, data stability and the gap between output-enable rising and the next write are measured at the pins for a 70 ns memory at an 8 ns clock. These measurements separate a correct cycle conversion from one that rounds down or drops a term from a maximum. A read followed at once by a write shows whether the turnaround window is kept.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_TURN,
      ST_WR,
      ST_WEND
   } seq_state_e;

   // Interval in cycles: ceiling of ns over period, never below one.
   function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
      int c;
      c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_strobe_timer.sv
module sram_strobe_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_lane.sv
module sram_strobe_lane (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       load_en,
   input  logic [7:0] load_byte,
   input  logic       strobe_on,
   input  logic       capture,
   input  logic [7:0] pin_byte,
   output logic       strobe_n,
   output logic [7:0] wbyte,
   output logic [7:0] rbyte
);

   logic en_q;
   logic en_nx;

   assign en_nx = load ? load_en : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         strobe_n <= 1'b1;
         wbyte    <= '0;
         rbyte    <= '0;
      end else begin
         en_q     <= en_nx;
         strobe_n <= !(strobe_on && en_nx);
         if (load)
            wbyte <= load_byte;
         if (capture)
            rbyte <= pin_byte;
      end
   end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_strobe_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16,
   parameter int CLK_PS = 8000,
   parameter int T_RC   = 55,
   parameter int T_AA   = 55,
   parameter int T_ACE  = 55,
   parameter int T_DOE  = 25,
   parameter int T_DBE  = 55,
   parameter int T_PWE  = 40,
   parameter int T_WC   = 55,
   parameter int T_SD   = 25,
   parameter int T_AW   = 40,
   parameter int T_SCE  = 40,
   parameter int T_BW   = 40,
   parameter int T_HZOE = 20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [DATA_W/8-1:0]    req_be,
   output logic                   rsp_rvalid,
   output logic [DATA_W-1:0]      rsp_rdata,
   output logic                   rsp_wdone,
   output logic [ADDR_W-1:0]      sram_addr,
   output logic                   sram_ce_n,
   output logic                   sram_oe_n,
   output logic                   sram_we_n,
   output logic [DATA_W/8-1:0]    sram_be_n,
   inout  wire  [DATA_W-1:0]      sram_dq
);

   localparam int LANES = DATA_W / 8;

   localparam int C_RC   = ns_to_cyc(T_RC, CLK_PS);
   localparam int C_AA   = ns_to_cyc(T_AA, CLK_PS);
   localparam int C_ACE  = ns_to_cyc(T_ACE, CLK_PS);
   localparam int C_DOE  = ns_to_cyc(T_DOE, CLK_PS);
   localparam int C_DBE  = ns_to_cyc(T_DBE, CLK_PS);
   localparam int C_PWE  = ns_to_cyc(T_PWE, CLK_PS);
   localparam int C_WC   = ns_to_cyc(T_WC, CLK_PS);
   localparam int C_SD   = ns_to_cyc(T_SD, CLK_PS);
   localparam int C_AW   = ns_to_cyc(T_AW, CLK_PS);
   localparam int C_SCE  = ns_to_cyc(T_SCE, CLK_PS);
   localparam int C_BW   = ns_to_cyc(T_BW, CLK_PS);
   localparam int C_HZOE = ns_to_cyc(T_HZOE, CLK_PS);

   localparam int RD_LEN   = imax(imax(imax(C_RC, C_AA), imax(C_ACE, C_DOE)), C_DBE);
   localparam int WE_LEN   = imax(imax(imax(C_PWE, C_SD), imax(C_AW, C_SCE)), C_BW);
   localparam int WEND_LEN = imax(1, C_WC - WE_LEN);
   localparam int TURN_LEN = C_HZOE;
   localparam int MAX_LEN  = imax(imax(RD_LEN, WE_LEN), imax(WEND_LEN, TURN_LEN));
   localparam int CW       = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (CLK_PS <= 0) begin : g_bad_clk
      $error("CLK_PS must be positive");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   seq_state_e    state_q, state_nx;
   logic          tm_load;
   logic [CW-1:0] tm_val;
   logic          tm_zero;
   logic          accept;
   logic          capture;
   logic          strobe_on;
   logic          drive_q;
   logic [DATA_W-1:0] dq_out;
   logic [DATA_W-1:0] rdata_lanes;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      state_nx = state_q;
      tm_load  = 1'b0;
      tm_val   = '0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (req_valid) begin
            tm_load = 1'b1;
            if (req_write) begin
               state_nx = ST_WR;
               tm_val   = CW'(WE_LEN - 1);
            end else begin
               state_nx = ST_RD;
               tm_val   = CW'(RD_LEN - 1);
            end
         end
         ST_RD: if (tm_zero) begin
            state_nx = ST_TURN;
            capture  = 1'b1;
            tm_load  = 1'b1;
            tm_val   = CW'(TURN_LEN - 1);
         end
         ST_TURN: if (tm_zero) state_nx = ST_IDLE;
         ST_WR: if (tm_zero) begin
            state_nx = ST_WEND;
            tm_load  = 1'b1;
            tm_val   = CW'(WEND_LEN - 1);
         end
         ST_WEND: if (tm_zero) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   assign strobe_on = (state_nx == ST_RD) || (state_nx == ST_WR) || (state_nx == ST_WEND);

   sram_strobe_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .zero     (tm_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         sram_ce_n  <= 1'b1;
         sram_oe_n  <= 1'b1;
         sram_we_n  <= 1'b1;
         drive_q    <= 1'b0;
         sram_addr  <= '0;
         rsp_rvalid <= 1'b0;
         rsp_wdone  <= 1'b0;
      end else begin
         state_q    <= state_nx;
         sram_ce_n  <= !strobe_on;
         sram_oe_n  <= !(state_nx == ST_RD);
         sram_we_n  <= !(state_nx == ST_WR);
         drive_q    <= (state_nx == ST_WR) || (state_nx == ST_WEND);
         rsp_rvalid <= capture;
         rsp_wdone  <= (state_q == ST_WEND) && tm_zero;
         if (accept)
            sram_addr <= req_addr;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      sram_strobe_lane u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (accept),
         .load_en   (req_write ? req_be[i] : 1'b1),
         .load_byte (req_wdata[i*8 +: 8]),
         .strobe_on (strobe_on),
         .capture   (capture),
         .pin_byte  (sram_dq[i*8 +: 8]),
         .strobe_n  (sram_be_n[i]),
         .wbyte     (dq_out[i*8 +: 8]),
         .rbyte     (rdata_lanes[i*8 +: 8])
      );
   end

   assign rsp_rdata = rdata_lanes;
   assign sram_dq   = drive_q ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
   parameter int ADDR_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_rvalid,
   input logic              rsp_wdone,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce_n,
   input logic              sram_oe_n,
   input logic              sram_we_n,
   input logic              drive_q
);

   // R3
   oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> sram_we_n);

   // R9
   no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> !drive_q);

   // R7
   drive_during_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> drive_q);

   // R6
   we_ends_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> !sram_ce_n);

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

   // R10
   idle_strobes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> sram_ce_n);

   // R4
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rvalid |=> !rsp_rvalid);

   // R10
   wdone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wdone |=> !rsp_wdone);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_rvalid (rsp_rvalid),
   .rsp_wdone  (rsp_wdone),
   .sram_addr  (sram_addr),
   .sram_ce_n  (sram_ce_n),
   .sram_oe_n  (sram_oe_n),
   .sram_we_n  (sram_we_n),
   .drive_q    (drive_q)
);

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;

   localparam int AW  = 18;
   localparam int DW  = 16;
   localparam int PER = 8000;
   // 70 ns grade
   localparam int RC = 70, AA = 70, ACE = 70, DOE = 35, DBE = 70;
   localparam int PWE = 45, WC = 70, SD = 30, AWT = 60, SCE = 60, BW = 60, HZOE = 25;

   function automatic int cyc(input int ns);
      int c;
      c = (ns * 1000 + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   int exp_rd, exp_we, exp_ce_wr, exp_sd, exp_hz;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic           req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic [DW-1:0]  req_wdata = '0;
   logic [1:0]     req_be = 2'b00;
   logic           req_ready, rsp_rvalid, rsp_wdone;
   logic [DW-1:0]  rsp_rdata;
   logic [AW-1:0]  sram_addr;
   logic           sram_ce_n, sram_oe_n, sram_we_n;
   logic [1:0]     sram_be_n;
   wire  [DW-1:0]  sram_dq;

   sram_strobe_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_PS(PER),
      .T_RC(RC), .T_AA(AA), .T_ACE(ACE), .T_DOE(DOE), .T_DBE(DBE),
      .T_PWE(PWE), .T_WC(WC), .T_SD(SD), .T_AW(AWT), .T_SCE(SCE),
      .T_BW(BW), .T_HZOE(HZOE)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .rsp_wdone(rsp_wdone),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq(sram_dq)
   );

   // Behavioural memory
   logic [15:0] mem [256];
   logic rd_on;
   assign rd_on = (sram_ce_n == 1'b0) && (sram_oe_n == 1'b0) && (sram_we_n == 1'b1);
   assign sram_dq[7:0]  = (rd_on && !sram_be_n[0]) ? mem[sram_addr[7:0]][7:0]  : 8'hzz;
   assign sram_dq[15:8] = (rd_on && !sram_be_n[1]) ? mem[sram_addr[7:0]][15:8] : 8'hzz;

   always @(posedge sram_we_n) begin
      if (sram_ce_n === 1'b0) begin
         if (sram_be_n[0] === 1'b0) mem[sram_addr[7:0]][7:0]  <= sram_dq[7:0];
         if (sram_be_n[1] === 1'b0) mem[sram_addr[7:0]][15:8] <= sram_dq[15:8];
      end
   end

   // Pin monitors
   int we_cnt = 0, we_last = 0, ce_cnt = 0, ce_last = 0, oe_cnt = 0, oe_last = 0;
   int sd_cnt = 0, sd_last = 0, gap = 0, gap_last = -1;
   logic [DW-1:0] dq_prev = '0;
   logic [1:0] be_at_fall = 2'b11;
   logic prev_we = 1'b1;
   logic oe_in_wr = 1'b0, addr_moved = 1'b0;
   logic [AW-1:0] addr_prev = '0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (sram_we_n == 1'b0) we_cnt++;
         else if (we_cnt > 0) begin we_last = we_cnt; we_cnt = 0; end
         if (sram_ce_n == 1'b0) ce_cnt++;
         else if (ce_cnt > 0) begin ce_last = ce_cnt; ce_cnt = 0; end
         if (sram_oe_n == 1'b0) oe_cnt++;
         else if (oe_cnt > 0) begin oe_last = oe_cnt; oe_cnt = 0; end
         if (sram_we_n == 1'b0) begin
            if (prev_we == 1'b1) begin
               sd_cnt = 1; be_at_fall = sram_be_n; gap_last = gap;
            end else if (sram_dq === dq_prev) sd_cnt++;
            else sd_cnt = 1;
            dq_prev = sram_dq;
         end else if (prev_we == 1'b0) sd_cnt_done();
         if (sram_oe_n == 1'b0) gap = 0;
         else if (gap < 1000) gap++;
         if (sram_ce_n == 1'b0 && sram_we_n == 1'b0 && sram_oe_n == 1'b0) oe_in_wr = 1'b1;
         if (sram_ce_n == 1'b0 && ce_cnt > 1 && sram_addr !== addr_prev) addr_moved = 1'b1;
         addr_prev = sram_addr;
         prev_we = sram_we_n;
      end
   end

   task automatic sd_cnt_done();
      // data seen at the rise must still match the held value
      sd_last = (sram_dq === dq_prev) ? sd_cnt : 0;
   endtask

   int checks = 0, fails = 0;

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic check_ge(input string req, input string what, input int act, input int lim);
      checks++;
      if (act < lim) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected>=%0d", req, what, act, lim);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "strobes in reset", {28'd0, sram_ce_n, sram_oe_n, sram_we_n, req_ready}, 32'hF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "strobes after reset", {28'd0, sram_ce_n, sram_oe_n, sram_we_n, req_ready}, 32'hF);
      check("R1", "byte strobes", {30'd0, sram_be_n}, 32'h3);
      check("R1", "bus released", {16'd0, sram_dq}, {16'd0, 16'hzzzz});
   endtask

   task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0; req_addr = '0; req_wdata = '0; req_be = 2'b00;
      check("R10", "ready low while busy", {31'd0, req_ready}, 32'd0);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
      int pulses = 0;
      oe_in_wr = 1'b0; addr_moved = 1'b0;
      issue(1'b1, a, d, be);
      for (int k = 0; k < 100; k++) begin
         if (rsp_wdone) pulses++;
         if (req_ready) break;
         @(negedge clk);
      end
      @(negedge clk);
      if (rsp_wdone) pulses++;
      check("R10", "wdone pulse count", pulses, 1);
      check("R2", "WE low cycles", we_last, exp_we);
      check("R6", "CE low cycles on write", ce_last, exp_ce_wr);
      check_ge("R6", "CE span vs write cycle", ce_last, cyc(WC));
      check("R5", "byte strobes at WE fall", {30'd0, be_at_fall}, {30'd0, ~be});
      check("R5", "OE stayed high in write", {31'd0, oe_in_wr}, 32'd0);
      check_ge("R7", "data held while WE low", sd_last, exp_sd);
      check("R11", "address stable", {31'd0, addr_moved}, 32'd0);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] expd, input string req);
      int pulses = 0;
      logic [DW-1:0] got = '0;
      addr_moved = 1'b0;
      issue(1'b0, a, '0, 2'b00);
      for (int k = 0; k < 100; k++) begin
         if (rsp_rvalid) begin pulses++; got = rsp_rdata; end
         if (req_ready) break;
         @(negedge clk);
      end
      @(negedge clk);
      check(req, "read data", {16'd0, got}, {16'd0, expd});
      check("R4", "rvalid pulse count", pulses, 1);
      check("R3", "OE low cycles", oe_last, exp_rd);
      check("R3", "CE low cycles on read", ce_last, exp_rd);
      check("R11", "address stable on read", {31'd0, addr_moved}, 32'd0);
   endtask

   task automatic t_full_lanes();
      do_write(18'h10, 16'hAAAA, 2'b11);
      do_read(18'h10, 16'hAAAA, "R5");
   endtask

   task automatic t_low_lane();
      do_write(18'h10, 16'h1234, 2'b01);
      do_read(18'h10, 16'hAA34, "R8");
   endtask

   task automatic t_high_lane();
      do_write(18'h20, 16'hCCCC, 2'b11);
      do_write(18'h20, 16'h5678, 2'b10);
      do_read(18'h20, 16'h56CC, "R8");
   endtask

   task automatic t_no_lane();
      do_write(18'h10, 16'hFFFF, 2'b00);
      do_read(18'h10, 16'hAA34, "R8");
   endtask

   task automatic t_turnaround();
      do_read(18'h20, 16'h56CC, "R3");
      gap_last = -1;
      do_write(18'h30, 16'h0F0F, 2'b11);
      check_ge("R9", "idle cycles after OE rise", gap_last, exp_hz);
      do_read(18'h30, 16'h0F0F, "R7");
   endtask

   initial begin
      exp_rd    = mx(mx(mx(cyc(RC), cyc(AA)), mx(cyc(ACE), cyc(DOE))), cyc(DBE));
      exp_we    = mx(mx(mx(cyc(PWE), cyc(SD)), mx(cyc(AWT), cyc(SCE))), cyc(BW));
      exp_ce_wr = exp_we + mx(1, cyc(WC) - exp_we);
      exp_sd    = mx(cyc(SD), exp_we);
      exp_hz    = cyc(HZOE);
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      t_reset();
      t_full_lanes();
      t_low_lane();
      t_high_lane();
      t_no_lane();
      t_turnaround();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule